// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Arbiter

This block gathers eight interrupt sources, picks one by a fixed ranking, and presents the 16-bit address pair of that source's slot in a vector table at the top of memory. Rank 0 is a system reset request and rank 1 is a non-maskable input that is captured on its rising edge. Ranks 2, 3 and 4 are external pins. Rank 5 is an internal timer overflow. Rank 6 is raised by either an internal serial completion or an external serial pin. Rank 7 is one more external pin. Ranks 2 to 7 pass through a per-source enable mask and a global enable before arbitration.

The CPU watches `irq_o`. To take the interrupt it raises `ack_i`. While `ack_i` is high the registered rank and vector stay frozen, so the CPU can fetch the pair at any point in the acknowledge window. An acknowledge given while rank 1 is presented clears the captured non-maskable edge. All controls are plain level pins. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `ivec_arbiter`

## Requirements
- R1: After `rst_n` is low, `irq_o` is 0, and `rank_o`, `vec_hi_o` and `vec_lo_o` are all zero.
- R2: When rank r is presented, `vec_hi_o` = 0xFFFF − 2·r and `vec_lo_o` = `vec_hi_o` − 1. Examples: rank 0 gives 0xFFFF:0xFFFE and rank 7 gives 0xFFF1:0xFFF0.
- R3: When several enabled sources are pending, the one with the lowest rank number is presented.
- R4: A high level on `rst_src_i` presents rank 0, whatever the mask, the global enable or the other requests.
- R5: A rising edge on `nmi_i` latches a rank-1 request. This request ignores `irq_mask_i` and `gie_i`. Holding `nmi_i` high afterwards creates no new request.
- R6: The latched rank-1 request stays until `ack_i` is high while rank 1 is presented. An acknowledge given while another rank is presented leaves it in place.
- R7: Rank k (2 to 7) can win only when `gie_i` is 1 and `irq_mask_i[k-2]` is 1.
- R8: Rank 6 is requested by `ser_done_i` or by `ext_pin_i[3]`. Ranks 2, 3 and 4 come from `ext_pin_i[0..2]`, rank 7 comes from `ext_pin_i[4]`, and rank 5 comes from `tmr_ovf_i`.
- R9: While `ack_i` is high, `irq_o`, `rank_o` and both vector outputs hold their values.
- R10: When no enabled request is pending, `irq_o` is 0 and `rank_o` and both vectors are zero.
- R11: The external inputs (`rst_src_i`, `nmi_i`, `ext_pin_i`) pass through a two-flop synchronizer. A level change on `ext_pin_i` reaches the outputs at the third rising clock edge and not before. The internal inputs `tmr_ovf_i` and `ser_done_i` reach the outputs at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_src_i | input | 1 | Rank-0 system reset request (level, external) |
| nmi_i | input | 1 | Non-maskable request, rising-edge (external) |
| ext_pin_i | input | 5 | External level requests: [0..2] ranks 2–4, [3] serial pin for rank 6, [4] rank 7 |
| tmr_ovf_i | input | 1 | Internal timer overflow, rank 5 |
| ser_done_i | input | 1 | Internal serial transmit/receive completion, rank 6 |
| irq_mask_i | input | 6 | Enable per source; bit k-2 enables rank k |
| gie_i | input | 1 | Global enable for ranks 2–7 |
| ack_i | input | 1 | CPU acknowledge; freezes the outputs and clears the rank-1 latch |
| irq_o | output | 1 | Interrupt request to the CPU |
| rank_o | output | 3 | Rank of the presented source |
| vec_hi_o | output | 16 | Upper address of the vector pair |
| vec_lo_o | output | 16 | Lower address of the vector pair |

## Verification
On every cycle, assertions check four things: the outputs stay frozen during acknowledge, an idle request shows all-zero outputs, rank 0 dominates, and a pending non-maskable request always wins unless rank 0 is active. They also check that the winner is the lowest pending rank and that the rank-1 latch drops after its acknowledge. Other behaviours need the bench's stimulus to show them: the exact vector values, every mask and request combination in a full sweep, the choice between the two rank-6 inputs, edge-only capture of the non-maskable pin, and the exact cycle latency of each input path.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int N_SRC  = 8;
  localparam int RANK_W = $clog2(N_SRC);
  localparam int N_MASK = N_SRC - 2;
  typedef logic [RANK_W-1:0] rank_t;
endpackage

// File: rtl/ivec_sync.sv
module ivec_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ivec_edge_latch.sv
module ivec_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;
  logic rise;

  assign rise = lvl_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_o <= (pend_o & ~clr_i) | rise;
    end
  end

  AST_NMI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !rise) |=> !pend_o); // R6
endmodule

// File: rtl/ivec_prio.sv
module ivec_prio
  import ivec_pkg::*;
#(
  parameter int N = N_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output rank_t        rank_o
);
  always_comb begin
    valid_o = 1'b0;
    rank_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        rank_o  = rank_t'(i);
      end
    end
  end

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (req_i[rank_o] && ((req_i & ((N'(1) << rank_o) - N'(1))) == '0))); // R3
  AST_ANY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |-> valid_o); // R3
endmodule

// File: rtl/ivec_arbiter.sv
module ivec_arbiter
  import ivec_pkg::*;
#(
  parameter logic [15:0] VEC_TOP     = 16'hFFFF,
  parameter int          N_PINS      = 5,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_src_i,
  input  logic              nmi_i,
  input  logic [N_PINS-1:0] ext_pin_i,
  input  logic              tmr_ovf_i,
  input  logic              ser_done_i,
  input  logic [N_MASK-1:0] irq_mask_i,
  input  logic              gie_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [RANK_W-1:0] rank_o,
  output logic [15:0]       vec_hi_o,
  output logic [15:0]       vec_lo_o
);
  localparam int SW = N_PINS + 2;

  logic [SW-1:0]     sync_q;
  logic              rst_s, nmi_s;
  logic [N_PINS-1:0] pin_s;
  logic              nmi_pend, nmi_clr;
  logic [N_MASK-1:0] lvl_raw, lvl_en;
  logic [N_SRC-1:0]  req;
  logic              win_v;
  rank_t             win_r;
  logic [15:0]       win_hi;

  ivec_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({rst_src_i, nmi_i, ext_pin_i}),
    .q_o(sync_q)
  );
  assign {rst_s, nmi_s, pin_s} = sync_q;

  assign nmi_clr = ack_i & irq_o & (rank_o == RANK_W'(1));

  ivec_edge_latch u_nmi (
    .clk(clk), .rst_n(rst_n),
    .lvl_i(nmi_s), .clr_i(nmi_clr), .pend_o(nmi_pend)
  );

  // maskable level sources, index k-2 for rank k
  assign lvl_raw = {pin_s[4], ser_done_i | pin_s[3], tmr_ovf_i, pin_s[2:0]};
  assign lvl_en  = lvl_raw & irq_mask_i & {N_MASK{gie_i}};
  assign req     = {lvl_en, nmi_pend, rst_s};

  ivec_prio #(.N(N_SRC)) u_prio (
    .clk(clk), .rst_n(rst_n), .req_i(req), .valid_o(win_v), .rank_o(win_r)
  );

  assign win_hi = VEC_TOP - {12'd0, win_r, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o    <= 1'b0;
      rank_o   <= '0;
      vec_hi_o <= '0;
      vec_lo_o <= '0;
    end else if (!ack_i) begin
      irq_o    <= win_v;
      rank_o   <= win_v ? win_r : '0;
      vec_hi_o <= win_v ? win_hi : '0;
      vec_lo_o <= win_v ? (win_hi - 16'd1) : '0;
    end
  end

  AST_ACK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> ($stable(irq_o) && $stable(rank_o) && $stable(vec_hi_o) && $stable(vec_lo_o))); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (rank_o == '0 && vec_hi_o == '0 && vec_lo_o == '0)); // R10
  AST_RESET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_s && !ack_i) |=> (irq_o && rank_o == '0)); // R4
  AST_NMI_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !rst_s && !ack_i) |=> (irq_o && rank_o == RANK_W'(1))); // R5
  AST_GIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_i && !rst_s && !nmi_pend && !ack_i) |=> !irq_o); // R7
endmodule

// File: tb/sim_ivec_arbiter.sv
`timescale 1ns/1ps
module sim_ivec_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_src_i = 1'b0, nmi_i = 1'b0, tmr_ovf_i = 1'b0, ser_done_i = 1'b0;
  logic [4:0]  ext_pin_i = '0;
  logic [5:0]  irq_mask_i = '0;
  logic        gie_i = 1'b0, ack_i = 1'b0;
  logic        irq_o;
  logic [2:0]  rank_o;
  logic [15:0] vec_hi_o, vec_lo_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ivec_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .rst_src_i(rst_src_i), .nmi_i(nmi_i),
    .ext_pin_i(ext_pin_i), .tmr_ovf_i(tmr_ovf_i), .ser_done_i(ser_done_i),
    .irq_mask_i(irq_mask_i), .gie_i(gie_i), .ack_i(ack_i),
    .irq_o(irq_o), .rank_o(rank_o), .vec_hi_o(vec_hi_o), .vec_lo_o(vec_lo_o)
  );

  function automatic logic [35:0] expv(int r);
    if (r < 0) return '0;
    return {1'b1, 3'(r), 16'hFFFF - 16'(2*r), 16'hFFFE - 16'(2*r)};
  endfunction

  task automatic chk(string tag, logic [35:0] exp);
    logic [35:0] got;
    got = {irq_o, rank_o, vec_hi_o, vec_lo_o};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // p: requests for ranks 2..7 (bit k-2), m: mask; m[0] picks the internal rank-6 input
  task automatic apply(logic [5:0] p, logic [5:0] m);
    @(negedge clk);
    ext_pin_i[2:0] = p[2:0];
    tmr_ovf_i      = p[3];
    ser_done_i     = m[0] ? p[4] : 1'b0;
    ext_pin_i[3]   = m[0] ? 1'b0 : p[4];
    ext_pin_i[4]   = p[5];
    irq_mask_i     = m;
  endtask

  function automatic int lowest(logic [5:0] en);
    for (int k = 0; k < 6; k++) if (en[k]) return k + 2;
    return -1;
  endfunction

  initial begin
    edges(3);
    chk("R1 reset state", '0);
    @(negedge clk); rst_n = 1'b1; gie_i = 1'b1;
    edges(4);
    chk("R10 idle after reset", '0);

    // R11 latency: external pin at 3rd edge, internal at 1st
    apply(6'b000001, 6'h3F);
    edges(2); chk("R11 pin not yet visible", '0);
    edges(1); chk("R11 pin at third edge", expv(2));
    apply(6'b000000, 6'h3F); edges(4);
    apply(6'b001000, 6'h3F);
    edges(1); chk("R11 timer at first edge", expv(5));
    apply(6'b000000, 6'h3F); edges(4);

    // R2 R3 R7 R8 sweep with global enable on
    for (int p = 0; p < 64; p++) begin
      for (int m = 0; m < 64; m++) begin
        apply(6'(p), 6'(m));
        edges(4);
        chk($sformatf("R3 R7 R8 R2 sweep p=%0d m=%0d", p, m), expv(lowest(6'(p & m))));
      end
    end
    // R7 global enable off
    @(negedge clk); gie_i = 1'b0;
    for (int p = 0; p < 64; p++) begin
      apply(6'(p), 6'h3F); edges(4);
      chk($sformatf("R7 gie off p=%0d", p), '0);
    end

    // R5: NMI ignores mask and gie, level does not retrigger
    @(negedge clk); nmi_i = 1'b1; irq_mask_i = '0; apply(6'b001000, 6'h00);
    edges(5); chk("R5 nmi with gie/mask off", expv(1));
    @(negedge clk); gie_i = 1'b1; irq_mask_i = 6'h3F;
    edges(10); chk("R6 nmi holds without ack", expv(1));
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
    edges(2); chk("R6 nmi cleared by ack, timer next", expv(5));
    edges(5); chk("R5 held nmi level no retrigger", expv(5));
    @(negedge clk); nmi_i = 1'b0; edges(4);
    @(negedge clk); nmi_i = 1'b1; edges(5);
    chk("R5 new rising edge", expv(1));

    // R4 and R6: ack while rank 0 presented leaves nmi pending
    @(negedge clk); rst_src_i = 1'b1; gie_i = 1'b0; edges(4);
    chk("R4 reset source overrides", expv(0));
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
    @(negedge clk); rst_src_i = 1'b0; edges(5);
    chk("R6 nmi survives ack of rank 0", expv(1));
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0; nmi_i = 1'b0; gie_i = 1'b1;
    edges(4); chk("R6 nmi cleared then timer", expv(5));

    // R9: outputs frozen during ack
    @(negedge clk); ack_i = 1'b1;
    apply(6'b000001, 6'h3F);
    for (int i = 0; i < 5; i++) begin
      edges(1); chk($sformatf("R9 frozen during ack cycle %0d", i), expv(5));
    end
    @(negedge clk); ack_i = 1'b0;
    edges(2); chk("R9 update after ack release", expv(2));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule